// File: doc/BRIEF.md
# Regulator VID Startup Sequencer

This block is the digital control core of a two-plane voltage regulator controller, with one core plane and one northbridge plane. It watches the enable, power-on-reset and PWROK inputs. When the controller is enabled, it decodes two strap pins into a startup voltage and holds that value. It then soft-starts both plane references from zero toward the held value at a slow fixed slope. When soft-start is finished and the external regulation-OK flag is true, it raises power-good.

After PWROK is asserted, the block accepts VID commands that a serial receiver has already decoded. Each command is a plane mask and a millivolt target. The addressed planes then move toward the new target at a faster fixed slope. If PWROK drops, both planes return to the held startup value. Losing enable or a power-on-reset event tri-states the drivers, forces power-good low and clears the held value. A mode pin selects a fixed-voltage mode that has its own strap table and ignores all commands.

References are unsigned values in units of 0.5 mV, and one period of `tick_i` stands for one microsecond. With the default parameters, soft-start adds 4 units (2 mV) per tick and a commanded move adds 15 units (7.5 mV) per tick.

Top module: `vid_seq_top`

## Requirements
- R1: In normal mode the strap pair {strap_clk_i, strap_dat_i} is decoded on the cycle that enable is first seen as 00→1100 mV, 01→1000 mV, 10→900 mV and 11→800 mV. This value is held, and both planes soft-start toward it.
- R2: If vfix_mode_i is high when enable is first seen, the decode is 00→1400 mV, 01→1200 mV, 10→1000 mV and 11→800 mV. In this mode, commands and PWROK edges never move any target.
- R3: Soft-start begins from 0 and raises each reference by 4 half-millivolt units on each clock edge where tick_i is high. It lands exactly on the held value. A reference never changes on an edge without a tick, except when it is cleared.
- R4: pgood_o is high only after soft-start has finished, and only while reg_ok_i is high.
- R5: While pwrok_i is low, cmd_valid_i has no effect on any target.
- R6: When pwrok_i is high after soft-start, a command moves every plane whose bit is set in cmd_plane_i (bit 0 = core, bit 1 = northbridge) toward 2×cmd_mv_i units. The move is 15 units per tick, up or down, and ends exactly on the target. No reference ever changes by more than 20 units in one cycle.
- R7: Commanded moves do not change pgood_o. This includes a core target of 0 mV.
- R8: On a falling edge of pwrok_i, all planes move back to the held startup value, and the straps are not read again. After pwrok_i rises again, targets stay put until the next command.
- R9: One edge after en_i is low or por_i is high, drv_en_o and pgood_o are low, every reference is 0 and the held value is cleared. A restart reads the straps again.
- R10: A command that arrives in the middle of a move redirects the ramp from its present value without a jump. A command to a plane that is already at the new target causes no motion.
- R11: busy_o[p] is high exactly when plane p's reference differs from its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle microsecond tick that advances ramps |
| en_i | input | 1 | Enable above threshold |
| por_i | input | 1 | Power-on-reset event, active high |
| pwrok_i | input | 1 | Processor power-OK |
| strap_clk_i | input | 1 | Strap pin, upper decode bit |
| strap_dat_i | input | 1 | Strap pin, lower decode bit |
| vfix_mode_i | input | 1 | Fixed-voltage mode select, sampled at enable |
| reg_ok_i | input | 1 | All planes within regulation |
| cmd_valid_i | input | 1 | Decoded VID command strobe |
| cmd_plane_i | input | NPLANES | Plane mask, bit 0 core, last bit northbridge |
| cmd_mv_i | input | MV_W | Command target in mV |
| drv_en_o | output | 1 | Drivers active (low means tri-state) |
| pgood_o | output | 1 | Power-good |
| ref_o | output | NPLANES*(MV_W+1) | Plane references in 0.5 mV units, plane p at bits p*(MV_W+1) and up |
| busy_o | output | NPLANES | Per-plane ramp in progress |

## Verification
The hardest state to reach is a command that lands while another ramp is still running, combined with a PWROK drop that has to restore a held value even though the straps have since changed. The stimulus changes the strap pins after startup and before pulling PWROK. It also sends a second command to the core plane a few ticks into a downward move. It powers the core plane off while power-good is high and then returns it through the PWROK path. A behavioural model advances on every edge and flags any per-cycle difference in references, busy flags, power-good or driver enable.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_SS  = 2'd1,
    ST_RUN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vid_strap_decode.sv
module vid_strap_decode #(
  parameter int MV_W = 12
) (
  input  logic            vfix_i,
  input  logic [1:0]      code_i,
  output logic [MV_W-1:0] mv_o
);
  always_comb begin
    unique case ({vfix_i, code_i})
      3'b000:  mv_o = MV_W'(1100);
      3'b001:  mv_o = MV_W'(1000);
      3'b010:  mv_o = MV_W'(900);
      3'b011:  mv_o = MV_W'(800);
      3'b100:  mv_o = MV_W'(1400);
      3'b101:  mv_o = MV_W'(1200);
      3'b110:  mv_o = MV_W'(1000);
      default: mv_o = MV_W'(800);
    endcase
  end
endmodule

// File: rtl/vid_ref_ramp.sv
module vid_ref_ramp #(
  parameter int HW         = 13,
  parameter int MAX_STEP_H = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [HW-1:0] step_i,
  input  logic [HW-1:0] tgt_i,
  output logic [HW-1:0] ref_o,
  output logic          busy_o
);
  localparam logic [HW-1:0] MaxStep = HW'(MAX_STEP_H);

  logic [HW-1:0] ref_q, ref_d, gap_up, gap_dn;

  assign gap_up = tgt_i - ref_q;
  assign gap_dn = ref_q - tgt_i;

  always_comb begin
    ref_d = ref_q;
    if (clr_i) ref_d = '0;
    else if (tick_i) begin
      if (ref_q < tgt_i)      ref_d = (gap_up <= step_i) ? tgt_i : ref_q + step_i;
      else if (ref_q > tgt_i) ref_d = (gap_dn <= step_i) ? tgt_i : ref_q - step_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_d;
  end

  assign ref_o  = ref_q;
  assign busy_o = (ref_q != tgt_i);

  a_r3_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(ref_q));

  a_r6_max_slope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (((ref_q >= $past(ref_q)) ? (ref_q - $past(ref_q))
                                         : ($past(ref_q) - ref_q)) <= MaxStep));

  a_r6_no_overshoot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ref_q <= tgt_i) |=> (ref_q <= $past(tgt_i)));
endmodule

// File: rtl/vid_seq_top.sv
module vid_seq_top
  import vid_seq_pkg::*;
#(
  parameter int NPLANES    = 2,
  parameter int MV_W       = 12,
  parameter int SS_STEP_H  = 4,
  parameter int VID_STEP_H = 15,
  parameter int MAX_STEP_H = 20
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          en_i,
  input  logic                          por_i,
  input  logic                          pwrok_i,
  input  logic                          strap_clk_i,
  input  logic                          strap_dat_i,
  input  logic                          vfix_mode_i,
  input  logic                          reg_ok_i,
  input  logic                          cmd_valid_i,
  input  logic [NPLANES-1:0]            cmd_plane_i,
  input  logic [MV_W-1:0]               cmd_mv_i,
  output logic                          drv_en_o,
  output logic                          pgood_o,
  output logic [NPLANES*(MV_W+1)-1:0]   ref_o,
  output logic [NPLANES-1:0]            busy_o
);
  localparam int HW = MV_W + 1;
  localparam logic [HW-1:0] SsStep  = HW'(SS_STEP_H);
  localparam logic [HW-1:0] VidStep = HW'(VID_STEP_H);

  seq_state_e st_q;
  logic [HW-1:0] hold_q;
  logic [NPLANES-1:0][HW-1:0] tgt_q;
  logic vfix_q, pwrok_q;
  logic active, clr, all_idle, pwrok_fell;
  logic [MV_W-1:0] dec_mv;
  logic [HW-1:0] step;
  logic [NPLANES-1:0] busy;

  assign active     = en_i & ~por_i;
  assign clr        = (st_q == ST_OFF) | ~active;
  assign step       = (st_q == ST_RUN) ? VidStep : SsStep;
  assign all_idle   = ~|busy;
  assign pwrok_fell = pwrok_q & ~pwrok_i;

  vid_strap_decode #(.MV_W(MV_W)) u_dec (
    .vfix_i (vfix_mode_i),
    .code_i ({strap_clk_i, strap_dat_i}),
    .mv_o   (dec_mv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwrok_q <= 1'b0;
    else         pwrok_q <= pwrok_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      hold_q <= '0;
      vfix_q <= 1'b0;
      tgt_q  <= '0;
    end else if (!active) begin
      st_q   <= ST_OFF;
      hold_q <= '0;
      vfix_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          hold_q <= {dec_mv, 1'b0};
          vfix_q <= vfix_mode_i;
          for (int p = 0; p < NPLANES; p++) tgt_q[p] <= {dec_mv, 1'b0};
          st_q   <= ST_SS;
        end
        ST_SS: if (all_idle) st_q <= ST_RUN;
        ST_RUN: begin
          if (!vfix_q) begin
            if (pwrok_fell) begin
              for (int p = 0; p < NPLANES; p++) tgt_q[p] <= hold_q;
            end else if (pwrok_i && cmd_valid_i) begin
              for (int p = 0; p < NPLANES; p++)
                if (cmd_plane_i[p]) tgt_q[p] <= {cmd_mv_i, 1'b0};
            end
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [HW-1:0] ref_p;
    vid_ref_ramp #(.HW(HW), .MAX_STEP_H(MAX_STEP_H)) u_ramp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .tick_i (tick_i),
      .step_i (step),
      .tgt_i  (tgt_q[p]),
      .ref_o  (ref_p),
      .busy_o (busy[p])
    );
    assign ref_o[p*HW +: HW] = ref_p;
  end

  assign busy_o   = busy;
  assign drv_en_o = (st_q != ST_OFF);
  assign pgood_o  = (st_q == ST_RUN) & reg_ok_i;

  a_r9_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (!drv_en_o && !pgood_o && ref_o == '0));

  a_r7_pgood_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgood_o && active) |=> (pgood_o || !reg_ok_i));

  a_r2_vfix_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && vfix_q && active) |=> $stable(tgt_q));

  a_r5_cmd_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && active && !pwrok_i && !pwrok_q) |=> $stable(tgt_q));
endmodule

// File: tb/vid_seq_top_bench.sv
`timescale 1ns/1ps
module vid_seq_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic en = 1'b0, por = 1'b0, pwrok = 1'b0, sc = 1'b0, sd = 1'b0, vfix = 1'b0;
  logic reg_ok = 1'b0, cmd_v = 1'b0;
  logic [1:0] cmd_mask = 2'b00;
  logic [11:0] cmd_mv = 12'd0;
  logic drv_en, pgood;
  logic [25:0] ref_flat;
  logic [1:0] busy;

  int checks = 0, fails = 0, cyc = 0, tcnt = 0;
  string cur_req = "R9";
  bit finished = 0;

  always #2.5 clk = ~clk;

  vid_seq_top u_vid_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .por_i(por),
    .pwrok_i(pwrok), .strap_clk_i(sc), .strap_dat_i(sd), .vfix_mode_i(vfix),
    .reg_ok_i(reg_ok), .cmd_valid_i(cmd_v), .cmd_plane_i(cmd_mask),
    .cmd_mv_i(cmd_mv), .drv_en_o(drv_en), .pgood_o(pgood),
    .ref_o(ref_flat), .busy_o(busy)
  );

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick <= (tcnt == 0);
  end

  // behavioural reference model, 0.5 mV units
  int m_st = 0, m_hold = 0, m_vfix = 0, m_pw = 0;
  int m_ref[2] = '{0, 0};
  int m_tgt[2] = '{0, 0};
  int prev_ref[2] = '{0, 0};
  int prev_st = 0;
  bit m_done;

  function automatic int strap_mv(bit v, bit c, bit d);
    int code = {c, d};
    return v ? 1400 - 200 * code : 1100 - 100 * code;
  endfunction

  task automatic m_step(int s);
    if (tick)
      for (int p = 0; p < 2; p++) begin
        if (m_ref[p] < m_tgt[p])
          m_ref[p] = (m_tgt[p] - m_ref[p] <= s) ? m_tgt[p] : m_ref[p] + s;
        else if (m_ref[p] > m_tgt[p])
          m_ref[p] = (m_ref[p] - m_tgt[p] <= s) ? m_tgt[p] : m_ref[p] - s;
      end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_hold = 0; m_vfix = 0; m_pw = 0;
      for (int p = 0; p < 2; p++) begin m_ref[p] = 0; m_tgt[p] = 0; end
    end else begin
      if (!en || por) begin
        m_st = 0; m_hold = 0; m_vfix = 0;
        for (int p = 0; p < 2; p++) begin m_ref[p] = 0; m_tgt[p] = 0; end
      end else if (m_st == 0) begin
        m_hold = 2 * strap_mv(vfix, sc, sd);
        m_vfix = vfix;
        for (int p = 0; p < 2; p++) begin m_ref[p] = 0; m_tgt[p] = m_hold; end
        m_st = 1;
      end else if (m_st == 1) begin
        m_done = (m_ref[0] == m_tgt[0]) && (m_ref[1] == m_tgt[1]);
        m_step(4);
        if (m_done) m_st = 2;
      end else begin
        m_step(15);
        if (!m_vfix) begin
          if (m_pw && !pwrok)
            for (int p = 0; p < 2; p++) m_tgt[p] = m_hold;
          else if (pwrok && cmd_v)
            for (int p = 0; p < 2; p++) if (cmd_mask[p]) m_tgt[p] = 2 * cmd_mv;
        end
      end
      m_pw = pwrok;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int dut_ref(int p);
    return int'(ref_flat[p*13 +: 13]);
  endfunction

  always @(posedge clk) begin
    #1;
    if (!finished) begin
      chk(drv_en == (m_st != 0), cur_req, "drv_en", drv_en, m_st != 0);
      chk(pgood == (m_st == 2 && reg_ok), cur_req, "pgood", pgood, m_st == 2 && reg_ok);
      for (int p = 0; p < 2; p++) begin
        chk(dut_ref(p) == m_ref[p], cur_req, "ref", dut_ref(p), m_ref[p]);
        chk(busy[p] == (m_ref[p] != m_tgt[p]), "R11", "busy", busy[p], m_ref[p] != m_tgt[p]);
        if (prev_st == 2 && m_st == 2) begin
          int d = dut_ref(p) - prev_ref[p];
          if (d < 0) d = -d;
          chk(d <= 20, "R6", "slope", d, 20);
        end
        prev_ref[p] = dut_ref(p);
      end
      prev_st = m_st;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [1:0] mask, int mv);
    @(negedge clk);
    cmd_v = 1'b1; cmd_mask = mask; cmd_mv = 12'(mv);
    @(negedge clk);
    cmd_v = 1'b0;
  endtask

  task automatic sample;
    @(posedge clk); #2;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    run(3);
    sample;
    chk(!drv_en && !pgood && ref_flat == 0, "R9", "reset state", int'(drv_en), 0);
    @(negedge clk) rst_n = 1'b1;
    run(4);
    sample;
    chk(!drv_en && !pgood, "R9", "disabled idle", int'(pgood), 0);

    // R1/R3: normal soft-start to 1000 mV
    cur_req = "R3";
    @(negedge clk); sc = 0; sd = 1; reg_ok = 1'b1; en = 1'b1;
    run(2200);
    sample;
    chk(dut_ref(0) == 2000 && dut_ref(1) == 2000, "R1", "ss final", dut_ref(0), 2000);
    chk(pgood == 1'b1, "R4", "pgood after ss", pgood, 1);
    cur_req = "R4";
    @(negedge clk) reg_ok = 1'b0;
    sample;
    chk(pgood == 1'b0, "R4", "pgood no reg_ok", pgood, 0);
    @(negedge clk) reg_ok = 1'b1;

    // R5: command without pwrok
    cur_req = "R5";
    send(2'b01, 1200);
    run(40);
    sample;
    chk(dut_ref(0) == 2000 && busy == 0, "R5", "cmd w/o pwrok", dut_ref(0), 2000);

    // R6: up and down moves
    cur_req = "R6";
    @(negedge clk) pwrok = 1'b1;
    run(4);
    send(2'b01, 1200);
    run(200);
    sample;
    chk(dut_ref(0) == 2400, "R6", "core up", dut_ref(0), 2400);
    send(2'b10, 800);
    run(200);
    sample;
    chk(dut_ref(1) == 1600, "R6", "nb down", dut_ref(1), 1600);

    // R10: retarget mid-move, and command to plane already there
    cur_req = "R10";
    send(2'b01, 900);
    run(40);
    send(2'b01, 1300);
    run(500);
    sample;
    chk(dut_ref(0) == 2600, "R10", "retarget final", dut_ref(0), 2600);
    send(2'b10, 800);
    run(20);
    sample;
    chk(busy[1] == 1'b0 && dut_ref(1) == 1600, "R10", "no motion", dut_ref(1), 1600);

    // R7: core off with pgood held
    cur_req = "R7";
    send(2'b01, 0);
    run(800);
    sample;
    chk(dut_ref(0) == 0 && pgood, "R7", "core off pgood", int'(pgood), 1);

    // R8: change straps, drop pwrok
    cur_req = "R8";
    @(negedge clk); sc = 1; sd = 1;
    @(negedge clk) pwrok = 1'b0;
    run(800);
    sample;
    chk(dut_ref(0) == 2000 && dut_ref(1) == 2000, "R8", "back to hold", dut_ref(0), 2000);
    @(negedge clk) pwrok = 1'b1;
    run(40);
    sample;
    chk(busy == 0 && dut_ref(1) == 2000, "R8", "wait after reassert", dut_ref(1), 2000);

    // R9: enable loss and restart with new straps
    cur_req = "R9";
    @(negedge clk) en = 1'b0;
    sample;
    chk(!drv_en && !pgood && ref_flat == 0, "R9", "en off", int'(drv_en), 0);
    run(5);
    @(negedge clk) en = 1'b1;
    run(1800);
    sample;
    chk(dut_ref(0) == 1600 && pgood, "R9", "restart 800", dut_ref(0), 1600);
    @(negedge clk) por = 1'b1;
    sample;
    chk(!drv_en && !pgood, "R9", "por off", int'(pgood), 0);
    @(negedge clk) por = 1'b0;

    // R2: fixed mode 1400 mV, commands and pwrok ignored
    cur_req = "R2";
    @(negedge clk); en = 1'b0; pwrok = 1'b0;
    run(3);
    @(negedge clk); vfix = 1'b1; sc = 0; sd = 0; en = 1'b1;
    run(3000);
    sample;
    chk(dut_ref(0) == 2800 && dut_ref(1) == 2800, "R2", "vfix level", dut_ref(1), 2800);
    @(negedge clk) pwrok = 1'b1;
    send(2'b11, 900);
    run(60);
    @(negedge clk) pwrok = 1'b0;
    run(60);
    sample;
    chk(dut_ref(0) == 2800 && busy == 0, "R2", "vfix ignores cmd", dut_ref(0), 2800);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule